// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects interrupt conditions from a serial peripheral and drives one shared request line. Each source owns a pending flag. A one-cycle pulse on the source's condition input sets that flag. Software enables sources by writing ones to a set register and disables them by writing ones to a clear register, so no read-modify-write of a mask is needed. Software writes ones to the flag register to acknowledge flags.

The request output is the OR of all flags that are both pending and enabled. After a request, software reads the flag register to find the cause. The source set depends on the mode. In slave mode the sources are error, data ready, address match and stop detected. In master mode they are error, remote-controller-on-bus and local-controller-on-bus. A mode input forces the sources that do not belong to the current mode out of the pending state.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags are 0, the enable mask is 0 and `irq_o` is 0.
- R2: A high `cond_i[k]` on a rising edge sets flag k in that cycle. The flag is visible on `rdata_o` and drives `irq_o` after that edge.
- R3: A write to the enable-set register (address 1) ORs `wdata_i` into the enable mask. Zero bits leave the mask unchanged.
- R4: A write to the enable-clear register (address 2) clears the mask bits where `wdata_i` is one. Zero bits leave the mask unchanged.
- R5: A write to the flag register (address 0) clears the flags where `wdata_i` is one. Zero bits leave the flags unchanged.
- R6: If a condition pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_o` is 1 exactly when some bit of (flags AND mask) is 1. A request stays asserted until the flag is cleared, the source is disabled or reset is applied.
- R8: Reads are combinational. Address 0 returns the flags. Addresses 1 and 2 both return the enable mask. Address 3 returns 0.
- R9: Bit positions are fixed. Bit 0 is error. In slave mode (`mode_i`=0) bits 1, 2 and 3 are data ready, address match and stop. In master mode (`mode_i`=1) bits 1 and 2 are remote-on-bus and local-on-bus, and bit 3 is unused. A flag outside the current mode's set is never set and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects slave sources, 1 selects master sources |
| cond_i | input | 4 | Per-source condition pulses |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for `addr_i` |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench lands a condition pulse and a clearing write on the same flag in the same cycle. A design where clear wins would show the flag as 0 and drop the request. It writes patterns with mixed zero and one bits to the set and clear registers. A design that loads the mask instead of ORing into it or masking it would change bits that the written value left at zero. It pulses bit 3 in master mode and checks that the flag stays 0 and no request appears. It also checks that a pending flag whose enable is removed stops driving the request while still reading as pending.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned N_SRC = 4;
  localparam int unsigned AW    = 2;

  typedef enum logic [AW-1:0] {
    REG_FLAG   = 2'd0,
    REG_EN_SET = 2'd1,
    REG_EN_CLR = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // valid source masks per mode
  localparam logic [N_SRC-1:0] SLV_MASK = 4'b1111;
  localparam logic [N_SRC-1:0] MST_MASK = 4'b0111;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q_o[k] <= 1'b0;
      else if (!valid_i[k])    q_o[k] <= 1'b0;
      else if (set_i[k])       q_o[k] <= 1'b1; // set beats clear
      else if (clr_i[k])       q_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_flag_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic [N-1:0] cond_i,
  input  logic         we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] rdata_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, en_q, valid;
  logic [N-1:0] flag_clr, en_set, en_clr;

  assign valid    = mode_i ? MST_MASK : SLV_MASK;
  assign flag_clr = (we_i && addr_i == REG_FLAG)   ? wdata_i : '0;
  assign en_set   = (we_i && addr_i == REG_EN_SET) ? wdata_i : '0;
  assign en_clr   = (we_i && addr_i == REG_EN_CLR) ? wdata_i : '0;

  irq_flag_bank #(.N(N)) u_flags (
    .clk_i, .rst_ni, .valid_i(valid), .set_i(cond_i), .clr_i(flag_clr), .q_o(flag_q)
  );

  irq_enable_reg #(.N(N)) u_en (
    .clk_i, .rst_ni, .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_FLAG:               rdata_o = flag_q;
      REG_EN_SET, REG_EN_CLR: rdata_o = en_q;
      default:                rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_i,
  input logic [N-1:0] cond_i,
  input logic         we_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0] wdata_i,
  input logic [N-1:0] flag_q,
  input logic [N-1:0] en_q,
  input logic         irq_o
);
  logic [N-1:0] valid;
  assign valid = mode_i ? MST_MASK : SLV_MASK;

  a_r2_cond_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(cond_i & valid) |=> |flag_q);
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i[0] && we_i && addr_i == REG_FLAG && wdata_i[0]) |=> flag_q[0]);
  a_r3_set_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_EN_SET && wdata_i[0]) |=> en_q[0]);
  a_r4_clr_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_EN_CLR && wdata_i[1]) |=> !en_q[1]);
  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i && $stable(mode_i)) |=> irq_o);
  a_r9_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i)) |-> !flag_q[3]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.N(N)) u_chk (
  .clk_i, .rst_ni, .mode_i, .cond_i, .we_i, .addr_i, .wdata_i,
  .flag_q, .en_q, .irq_o
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic clk = 0, rst_n = 0, mode = 0, we = 0;
  logic [3:0] cond = 0, wdata = 0;
  logic [1:0] addr = 0;
  logic [3:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [3:0] m_flag = 0, m_en = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl u_dut (.clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cond_i(cond),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [3:0] vmask(input logic md);
    return md ? 4'b0111 : 4'b1111;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one cycle, update model at edge
  task automatic step(input logic [3:0] c, input logic w, input logic [1:0] a, input logic [3:0] d);
    cond = c; we = w; addr = a; wdata = d;
    @(posedge clk);
    m_flag = (w && a == 0) ? (m_flag & ~d) : m_flag;
    m_flag = (m_flag | c) & vmask(mode);
    if (w && a == 1) m_en = m_en | d;
    if (w && a == 2) m_en = m_en & ~d;
    #1; cond = 0; we = 0; addr = 0; wdata = 0;
  endtask

  task automatic verify(input string req);
    addr = 0; #1; chk(req, rdata, m_flag);
    addr = 1; #1; chk(req, rdata, m_en);
    addr = 2; #1; chk(req, rdata, m_en);
    addr = 3; #1; chk({req, " R8"}, rdata, 4'h0);
    addr = 0;
    chk({req, " R7"}, {3'b0, irq}, {3'b0, |(m_flag & m_en)});
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog act=hang exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20; verify("R1 reset");
    rst_n = 1; @(negedge clk);
    step(4'b0010, 0, 0, 0); verify("R2 set");
    step(0, 1, 1, 4'b0110); verify("R3 set en");
    step(0, 1, 1, 4'b0001); verify("R3 or");
    step(0, 1, 2, 4'b0100); verify("R4 clr en");
    step(0, 1, 0, 4'b0010); verify("R5 clr flag");
    step(4'b0001, 0, 0, 0); verify("R7 irq");
    step(4'b0001, 1, 0, 4'b0001); verify("R6 set wins");
    step(0, 1, 2, 4'b0001); verify("R7 disable drops irq");
    chk("R7 flag kept", {3'b0, m_flag[0]}, 4'h1);
    step(0, 1, 1, 4'b0001); verify("R7 reenable");
    step(0, 1, 0, 4'b1111); verify("R5 clear all");
    mode = 1;
    step(4'b1000, 0, 0, 0); verify("R9 master bit3");
    step(4'b0110, 0, 0, 0); verify("R9 master srcs");
    for (int i = 0; i < 300; i++) begin
      mode = ($urandom % 8 == 0) ? ~mode : mode;
      step($urandom % 16, $urandom % 2, $urandom % 4, $urandom % 16);
      verify("R2-rand");
    end
    step(4'b0011, 1, 1, 4'b1111); verify("R7 pre-reset");
    rst_n = 0; m_flag = 0; m_en = 0; #2; verify("R1 async reset");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule